// File: doc/BRIEF.md
# Delay-Compensating Shared SRAM Interface

This block connects a shared processor bus to one synchronous SRAM that several processing elements use as global memory. Each requester reaches the memory through a wire path of a different length, so a fixed access time is either too short for the far requesters or wasteful for the near ones. The interface therefore stretches every access by a whole number of clock cycles that belongs to the requester holding the bus at that moment. The counts are a parameter table with one entry per requester. A mode input chooses no stretching, the per-requester count, or the largest count in the table applied to everyone.

A requester starts a transfer by raising `xfer_start` for one cycle. With that strobe it presents its identifier, the direction, a byte address and, for a write, the data. The controller drives active-low chip select and read or write strobes to the SRAM. It answers with a one-cycle active-low address acknowledge when the access opens and a one-cycle active-low data acknowledge when it completes. The SRAM is addressed in 64-bit words, so the three byte-offset bits of the bus address are dropped.

The controller is a four-state machine. `ST_IDLE` moves to `ST_ADDR` on an accepted start. `ST_ADDR` moves to `ST_DONE` when the loaded extra count is zero, and to `ST_WAIT` otherwise. `ST_WAIT` stays while the countdown is above one and moves to `ST_DONE` on its last cycle. `ST_DONE` always returns to `ST_IDLE`. A synchronous reset forces `ST_IDLE` from any state.

Top module: `sdc_sram_if`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller goes idle. After that edge `mem_cs_n`, `mem_we_n`, `mem_re_n`, `addr_ack_n` and `data_ack_n` are all high and `bus_rdata` is zero. This holds even if an access was in progress.
- R2: `addr_ack_n` is low for exactly one cycle, the first cycle in which `mem_cs_n` is low.
- R3: Let E be the extra cycle count. `mem_cs_n` stays low for E+2 consecutive cycles. `mode` is sampled with the start: 2'b00 gives E=0, 2'b01 gives the table entry of `req_id`, and 2'b10 or 2'b11 gives the largest table entry. The default table is 3, 2, 0 and 5 for requesters 0, 1, 2 and 3.
- R4: `data_ack_n` is low for exactly one cycle, the last cycle of chip select (cycle E+2). The strobes are high in that cycle.
- R5: On a read (`xfer_wr`=0), `mem_re_n` is low for cycles 1 to E+1. The SRAM data present at the end of cycle E+1 appears on `bus_rdata` in cycle E+2, together with `data_ack_n`. At all other times `bus_rdata` is zero.
- R6: On a write (`xfer_wr`=1), `mem_we_n` is low for cycles 1 to E+1 and `mem_wdata` stays stable over that time. `mem_we_n` goes high one cycle before `mem_cs_n` does.
- R7: `mem_addr` equals bus address bits [23:3]. It stays stable for the whole time chip select is low.
- R8: Requester ID, mode, direction, address and data are taken only from the start cycle. A start that arrives while an access is in progress is ignored, so it changes neither the timing nor the SRAM-side values.
- R9: `mem_we_n` and `mem_re_n` are never low together, and neither is low while `mem_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Compensation mode, sampled with the start |
| xfer_start | input | 1 | Transfer start strobe, active high |
| req_id | input | 2 | Identifier of the requester owning the bus |
| xfer_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address from the bus |
| bus_wdata | input | 64 | Write data from the bus |
| bus_rdata | output | 64 | Read data to the bus, valid with the data acknowledge |
| addr_ack_n | output | 1 | Address acknowledge, active low |
| data_ack_n | output | 1 | Data transfer acknowledge, active low |
| mem_cs_n | output | 1 | SRAM chip select, active low |
| mem_we_n | output | 1 | SRAM write strobe, active low |
| mem_re_n | output | 1 | SRAM read strobe, active low |
| mem_addr | output | 21 | SRAM word address |
| mem_wdata | output | 64 | SRAM write data |
| mem_rdata | input | 64 | SRAM read data |

## Verification
The properties assume that `rst_n` is low at the first clock edge. They also assume that the SRAM drives valid read data while the read strobe is low, and that a requester ID always names an existing table entry. The bench gives the memory model a combinational read path that is gated by chip select and the read strobe. IDs are drawn only from 0 to 3. Starts arriving during an access are injected on purpose, with inverted address and data and a different ID, so that ignoring them is visible at the SRAM pins.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } sdc_state_e;

    typedef enum logic [1:0] {
        MD_NONE      = 2'b00,
        MD_PATH      = 2'b01,
        MD_WORST     = 2'b10,
        MD_WORST_ALT = 2'b11
    } sdc_mode_e;

endpackage

// File: rtl/sdc_wait_select.sv
module sdc_wait_select
    import sdc_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int WAIT_W = 4,
    parameter int IDW    = 2,
    parameter logic [N_REQ*WAIT_W-1:0] WAIT_TABLE = '0
) (
    input  logic [1:0]        mode,
    input  logic [IDW-1:0]    req_id,
    output logic [WAIT_W-1:0] extra
);

    logic [WAIT_W-1:0] per_req [N_REQ];
    logic [WAIT_W-1:0] run_max [N_REQ];
    logic [WAIT_W-1:0] own_cnt;

    for (genvar i = 0; i < N_REQ; i++) begin : g_entry
        assign per_req[i] = WAIT_TABLE[i*WAIT_W +: WAIT_W];
        if (i == 0) begin : g_first
            assign run_max[i] = per_req[i];
        end else begin : g_rest
            assign run_max[i] = (per_req[i] > run_max[i-1]) ? per_req[i] : run_max[i-1];
        end
    end

    always_comb begin
        own_cnt = '0;
        for (int j = 0; j < N_REQ; j++) begin
            if (int'(req_id) == j) own_cnt = per_req[j];
        end
    end

    always_comb begin
        unique case (sdc_mode_e'(mode))
            MD_NONE:      extra = '0;
            MD_PATH:      extra = own_cnt;
            MD_WORST:     extra = run_max[N_REQ-1];
            MD_WORST_ALT: extra = run_max[N_REQ-1];
            default:      extra = '0;
        endcase
    end

endmodule

// File: rtl/sdc_countdown.sv
module sdc_countdown #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              zero,
    output logic              last
);

    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - WAIT_W'(1);
        end
    end

    assign zero = (cnt == '0);
    assign last = (cnt == WAIT_W'(1));

endmodule

// File: rtl/sdc_sram_if.sv
module sdc_sram_if
    import sdc_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int BUS_AW = 32,
    parameter int BUS_DW = 64,
    parameter int MEM_AW = 21,
    parameter int WAIT_W = 4,
    parameter logic [N_REQ*WAIT_W-1:0] WAIT_TABLE = {4'd5, 4'd0, 4'd2, 4'd3},
    parameter int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              xfer_start,
    input  logic [IDW-1:0]    req_id,
    input  logic              xfer_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              addr_ack_n,
    output logic              data_ack_n,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_re_n,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [BUS_DW-1:0] mem_wdata,
    input  logic [BUS_DW-1:0] mem_rdata
);

    localparam int OFS = $clog2(BUS_DW / 8);
    localparam int TOP = MEM_AW + OFS;

    sdc_state_e        state, state_nx;
    logic [WAIT_W-1:0] extra;
    logic              accept, cnt_zero, cnt_last, capture, strobe_on;
    logic [MEM_AW-1:0] addr_q;
    logic [BUS_DW-1:0] wdata_q, rdata_q;
    logic              wr_q;
    logic              addr_unused;

    assign addr_unused = ^{bus_addr[BUS_AW-1:TOP], bus_addr[OFS-1:0]};

    sdc_wait_select #(
        .N_REQ(N_REQ), .WAIT_W(WAIT_W), .IDW(IDW), .WAIT_TABLE(WAIT_TABLE)
    ) u_sel (
        .mode(mode), .req_id(req_id), .extra(extra)
    );

    sdc_countdown #(.WAIT_W(WAIT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(extra),
        .dec(state == ST_WAIT), .zero(cnt_zero), .last(cnt_last)
    );

    assign accept  = (state == ST_IDLE) && xfer_start;
    assign capture = !wr_q && (((state == ST_ADDR) && cnt_zero) ||
                               ((state == ST_WAIT) && cnt_last));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (xfer_start) state_nx = ST_ADDR;
            ST_ADDR: state_nx = cnt_zero ? ST_DONE : ST_WAIT;
            ST_WAIT: if (cnt_last) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= bus_addr[TOP-1:OFS];
                wdata_q <= bus_wdata;
                wr_q    <= xfer_wr;
            end
            if (capture) rdata_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_cs_n   = 1'b1;
        strobe_on  = 1'b0;
        addr_ack_n = 1'b1;
        data_ack_n = 1'b1;
        bus_rdata  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR: begin
                mem_cs_n   = 1'b0;
                strobe_on  = 1'b1;
                addr_ack_n = 1'b0;
            end
            ST_WAIT: begin
                mem_cs_n  = 1'b0;
                strobe_on = 1'b1;
            end
            ST_DONE: begin
                mem_cs_n   = 1'b0;
                data_ack_n = 1'b0;
                if (!wr_q) bus_rdata = rdata_q;
            end
            default: ;
        endcase
    end

    assign mem_we_n  = !(strobe_on && wr_q);
    assign mem_re_n  = !(strobe_on && !wr_q);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/sdc_sram_if_chk.sv
module sdc_sram_if_chk #(
    parameter int MEM_AW = 21,
    parameter int BUS_DW = 64,
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_re_n,
    input logic              addr_ack_n,
    input logic              data_ack_n,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [BUS_DW-1:0] mem_wdata
);

    localparam int LIM = (2 ** WAIT_W) + 1;

    logic [WAIT_W+1:0] cs_run;

    always_ff @(posedge clk) begin
        if (!rst_n)        cs_run <= '0;
        else if (!mem_cs_n) cs_run <= cs_run + 1'b1;
        else               cs_run <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (mem_cs_n && mem_we_n && mem_re_n && addr_ack_n && data_ack_n)); // R1
    AST_AACK_OPENS: assert property (@(posedge clk) disable iff (!rst_n) !addr_ack_n |-> $fell(mem_cs_n)); // R2
    AST_AACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !addr_ack_n |=> addr_ack_n); // R2
    AST_CS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) int'(cs_run) <= LIM); // R3
    AST_TACK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) !data_ack_n |=> (data_ack_n && mem_cs_n)); // R4
    AST_TACK_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !data_ack_n |-> (!mem_cs_n && mem_we_n && mem_re_n)); // R4
    AST_WE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_cs_n) |-> $past(mem_we_n)); // R6
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_wdata)); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_we_n && !mem_re_n)); // R9
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n || !mem_re_n) |-> !mem_cs_n); // R9

endmodule

bind sdc_sram_if sdc_sram_if_chk #(
    .MEM_AW(MEM_AW), .BUS_DW(BUS_DW), .WAIT_W(WAIT_W)
) u_chk (.*);

// File: tb/tb_sdc_sram_if.sv
module tb_sdc_sram_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        xfer_start = 1'b0;
    logic [1:0]  req_id = 2'd0;
    logic        xfer_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        addr_ack_n, data_ack_n, mem_cs_n, mem_we_n, mem_re_n;
    logic [20:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;

    logic [63:0] model_mem [256];
    logic [63:0] shadow    [256];
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdc_sram_if dut (.*);

    assign mem_rdata = (!mem_cs_n && !mem_re_n) ? model_mem[mem_addr[7:0]] : 64'hBADD_BADD_BADD_BADD;
    always @(posedge clk) if (!mem_cs_n && !mem_we_n) model_mem[mem_addr[7:0]] <= mem_wdata;

    function automatic int exp_extra(input logic [1:0] md, input logic [1:0] id);
        int tbl [4] = '{3, 2, 0, 5};
        if (md == 2'b00) return 0;
        if (md == 2'b01) return tbl[id];
        return 5;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: act=%h exp=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "cs_n", mem_cs_n, 1);
        chk(req, "we_n", mem_we_n, 1);
        chk(req, "re_n", mem_re_n, 1);
        chk(req, "aack_n", addr_ack_n, 1);
        chk(req, "tack_n", data_ack_n, 1);
        chk(req, "rdata", bus_rdata, 0);
    endtask

    task automatic do_access(input logic [1:0] md, input logic [1:0] id, input logic wr,
                             input logic [31:0] addr, input logic [63:0] wd, input bit inject);
        int e = exp_extra(md, id);
        logic [20:0] ea = addr[23:3];
        logic [63:0] er = shadow[addr[10:3]];
        string atag = inject ? "R8" : "R7";
        mode = md; req_id = id; xfer_wr = wr; bus_addr = addr; bus_wdata = wd; xfer_start = 1'b1;
        if (wr) shadow[addr[10:3]] = wd;
        @(negedge clk);
        xfer_start = 1'b0;
        for (int k = 1; k <= e + 3; k++) begin
            if (inject && k == 1) begin
                xfer_start = 1'b1; req_id = id ^ 2'd3; xfer_wr = !wr;
                bus_addr = ~addr; bus_wdata = ~wd; mode = 2'b10;
            end
            if (inject && k == e + 2) xfer_start = 1'b0;
            if (k == e + 3) begin
                chk_idle(inject ? "R8" : "R3");
            end else begin
                chk("R3", "cs_n", mem_cs_n, 0);
                chk("R2", "aack_n", addr_ack_n, (k == 1) ? 0 : 1);
                chk("R4", "tack_n", data_ack_n, (k == e + 2) ? 0 : 1);
                chk(wr ? "R6" : "R9", "we_n", mem_we_n, (wr && k <= e + 1) ? 0 : 1);
                chk(wr ? "R9" : "R5", "re_n", mem_re_n, (!wr && k <= e + 1) ? 0 : 1);
                chk(atag, "mem_addr", mem_addr, ea);
                if (wr && k <= e + 1) chk("R6", "mem_wdata", mem_wdata, wd);
                if (!wr && k == e + 2) chk("R5", "rdata", bus_rdata, er);
                else chk("R5", "rdata_zero", bus_rdata, 0);
            end
            if (k < e + 3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog: act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240817));
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = {32'hC0DE_0000 | 32'(i), 32'(i * 7)};
            shadow[i]    = model_mem[i];
        end
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // directed: each mode, each requester, both directions (R3 R5 R6 R7)
        for (int md = 0; md < 4; md++) begin
            for (int id = 0; id < 4; id++) begin
                logic [31:0] a = {8'hA5, 16'(md * 4 + id), 8'h0} | 32'((md * 4 + id) << 3) | 32'h5;
                do_access(2'(md), 2'(id), 1'b1, a, {32'(md), 32'hFACE_0000 | 32'(id)}, 1'b0);
                do_access(2'(md), 2'(id), 1'b0, a, '0, 1'b0);
            end
        end

        // zero-extra boundary and largest count with late starts (R8)
        do_access(2'b01, 2'd2, 1'b0, 32'h0000_0018, '0, 1'b1);
        do_access(2'b01, 2'd3, 1'b1, 32'hFF80_07F8, 64'h0123_4567_89AB_CDEF, 1'b1);
        do_access(2'b00, 2'd3, 1'b0, 32'hFF80_07F8, '0, 1'b1);

        // reset in the middle of an access (R1)
        mode = 2'b10; req_id = 2'd0; xfer_wr = 1'b0; bus_addr = 32'h40; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [31:0] a  = $urandom();
            logic [63:0] d  = {$urandom(), $urandom()};
            logic [1:0]  md = 2'($urandom_range(0, 3));
            logic [1:0]  id = 2'($urandom_range(0, 3));
            do_access(md, id, 1'($urandom_range(0, 1)), a, d, ($urandom_range(0, 3) == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule